// File: doc/BRIEF.md
# Row/Column Multiplexed Programming Port

This block is the parallel port used to program a flash array on the production line. A 20-bit array address is sent as two halves over one 11-bit address bus. A row/column select line picks which half the bus carries. The port builds the full address from the two halves. It turns write-enable pulses into single-cycle write requests and puts read data on the data bus only when the part is enabled and its outputs are turned on. It also shows the ready bit of the internal status byte on a ready/busy pin.

The port only carries plain array traffic: reads, byte-program data and erase command bytes. Command decoding, lock registers and other register features lie beyond it. A strap input selects this port. The strap is sampled while reset is asserted and is frozen when reset is released. While the strap reads low, the port stays inert.

All pins are sampled on `clk`. They are assumed to be synchronous to it already. The bidirectional data bus is split into `data_in`, `data_out` and a drive enable, `data_oe`. A pad cell outside the block joins them.

Top module: `rcm_prog_port`

## Requirements
- R1: While and after reset, with no pin activity, the assembled address is 0, `mem_wr` and `data_oe` are low and `data_out` is 0.
- R2: `mode_strap` is sampled only while `rst_n` is low. If it was low at reset release, the port is inert until the next reset: no write request, no read strobe, `data_oe` low, and `rdy_busy` high whatever the status.
- R3: On a falling edge of `rc_sel`, all 11 address pins are stored as address bits 10..0. The new value appears on `mem_addr` on the following cycle.
- R4: On a rising edge of `rc_sel`, address pins 8..0 are stored as address bits 19..11. Pins 10 and 9 have no effect in this phase.
- R5: On a rising edge of `we_n` with `ce_n` low, `mem_wr` is high for exactly one cycle, starting on the following cycle. During that cycle `mem_wdata` holds `data_in` as sampled at the edge, and `mem_addr` holds the address assembled at the edge.
- R6: A rising edge of `we_n` while `ce_n` is high produces no write request.
- R7: While `ce_n` and `oe_n` are low and `we_n` is high, `mem_rd` and `data_oe` are high. In the same cycle, `data_out` equals `mem_rdata`, read from the address shown on `mem_addr`.
- R8: Whenever `ce_n` or `oe_n` is high, `data_oe` is low and `data_out` is 0.
- R9: In active mode, `rdy_busy` follows the ready bit of the status byte (bit 7, 1 = ready). It is low while an internal operation is busy.
- R10: After reset release, the active/inert mode does not change, even if `mode_strap` toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; the mode strap is sampled while it is low |
| mode_strap | input | 1 | 1 selects this programming port |
| addr_pins | input | 11 | Shared address bus carrying the row half or the column half |
| rc_sel | input | 1 | Row/column select; falling edge latches the row, rising edge latches the column |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable; rising edge captures the write |
| data_in | input | 8 | Data bus, inbound side |
| data_out | output | 8 | Data bus, outbound side (0 when not driven) |
| data_oe | output | 1 | Drive enable for the data bus pads |
| rdy_busy | output | 1 | Ready (1) / busy (0) |
| mem_addr | output | 20 | Address to the array and command logic |
| mem_wr | output | 1 | One-cycle write request |
| mem_wdata | output | 8 | Write data captured with the request |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data returned for `mem_addr` |
| status_ready | input | 1 | Bit 7 of the internal status byte |

## Verification
The edge properties assume that `rc_sel` and `we_n` sit high, their idle level, through reset and in the first cycle after it. That way, every edge they see is a real pin transition seen by the design's own edge registers. They also assume that any pin pulse lasts at least one full clock cycle. The bench drives every pin only on the falling clock edge. It holds each level for at least one full cycle and keeps `rc_sel` and `we_n` high across every reset. This keeps all strobe edges clean, single and visible to the design.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  // Build the array address from its two halves: column on top, row below.
  function automatic logic [19:0] rcm_join(input logic [8:0] col_half,
                                           input logic [10:0] row_half);
    return {col_half, row_half};
  endfunction
endpackage

// File: rtl/rcm_addr_latch.sv
module rcm_addr_latch #(
  parameter int ROW_W = 11,
  parameter int COL_W = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ROW_W-1:0]       addr_pins,
  input  logic                   rc_sel,
  output logic                   row_evt,
  output logic                   col_evt,
  output logic [ROW_W+COL_W-1:0] asm_addr
);
  logic             rc_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  assign row_evt = rc_q & ~rc_sel;
  assign col_evt = ~rc_q & rc_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rc_q  <= 1'b1;
      row_q <= '0;
      col_q <= '0;
    end else begin
      rc_q <= rc_sel;
      if (row_evt) row_q <= addr_pins;
      if (col_evt) col_q <= addr_pins[COL_W-1:0];
    end
  end

  assign asm_addr = {col_q, row_q};
endmodule

// File: rtl/rcm_write_capture.sv
module rcm_write_capture #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] asm_addr,
  input  logic [DW-1:0] data_in,
  output logic          we_rise,
  output logic          wr_pulse,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic we_q;

  assign we_rise = ~we_q & we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q     <= 1'b1;
      wr_pulse <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      we_q     <= we_n;
      wr_pulse <= enable & ~ce_n & we_rise;
      if (enable & ~ce_n & we_rise) begin
        wr_addr <= asm_addr;
        wr_data <= data_in;
      end
    end
  end
endmodule

// File: rtl/rcm_read_gate.sv
module rcm_read_gate #(
  parameter int DW = 8
) (
  input  logic          enable,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [DW-1:0] rdata,
  output logic          rd_active,
  output logic [DW-1:0] data_out
);
  always_comb begin
    rd_active = enable & ~ce_n & ~oe_n & we_n;
    data_out  = rd_active ? rdata : '0;
  end
endmodule

// File: rtl/rcm_prog_port.sv
module rcm_prog_port #(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 9,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_strap,
  input  logic [ROW_W-1:0]       addr_pins,
  input  logic                   rc_sel,
  input  logic                   ce_n,
  input  logic                   oe_n,
  input  logic                   we_n,
  input  logic [DATA_W-1:0]      data_in,
  output logic [DATA_W-1:0]      data_out,
  output logic                   data_oe,
  output logic                   rdy_busy,
  output logic [ROW_W+COL_W-1:0] mem_addr,
  output logic                   mem_wr,
  output logic [DATA_W-1:0]      mem_wdata,
  output logic                   mem_rd,
  input  logic [DATA_W-1:0]      mem_rdata,
  input  logic                   status_ready
);
  localparam int AW = ROW_W + COL_W;

  // Named internal events for the checker.
  logic          mode_q;
  logic          row_evt, col_evt, we_rise;
  logic [AW-1:0] asm_addr, wr_addr;
  logic          wr_pulse, rd_active;

  // The strap is followed only while reset is held, then frozen.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_strap;
  end

  rcm_addr_latch #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr_pins(addr_pins), .rc_sel(rc_sel),
    .row_evt(row_evt), .col_evt(col_evt), .asm_addr(asm_addr)
  );

  rcm_write_capture #(.AW(AW), .DW(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .enable(mode_q), .ce_n(ce_n), .we_n(we_n),
    .asm_addr(asm_addr), .data_in(data_in), .we_rise(we_rise),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(mem_wdata)
  );

  rcm_read_gate #(.DW(DATA_W)) u_rd (
    .enable(mode_q), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rdata(mem_rdata), .rd_active(rd_active), .data_out(data_out)
  );

  assign mem_wr   = wr_pulse;
  assign mem_addr = wr_pulse ? wr_addr : asm_addr;
  assign mem_rd   = rd_active;
  assign data_oe  = rd_active;
  assign rdy_busy = ~mode_q | status_ready;
endmodule

// File: rtl/rcm_port_checker.sv
module rcm_port_checker #(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 9,
  parameter int DATA_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mode_q,
  input logic [ROW_W-1:0]       addr_pins,
  input logic                   rc_sel,
  input logic                   ce_n,
  input logic                   oe_n,
  input logic                   we_n,
  input logic [DATA_W-1:0]      data_in,
  input logic [DATA_W-1:0]      data_out,
  input logic                   data_oe,
  input logic                   rdy_busy,
  input logic [ROW_W+COL_W-1:0] asm_addr,
  input logic                   mem_wr,
  input logic [DATA_W-1:0]      mem_wdata,
  input logic                   status_ready
);
  a_r3_row_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(rc_sel)) |=> asm_addr[ROW_W-1:0] == $past(addr_pins));

  a_r4_col_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(rc_sel)) |=>
      asm_addr[ROW_W+COL_W-1:ROW_W] == $past(addr_pins[COL_W-1:0]));

  a_r5_write_req: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mode_q && !ce_n && $rose(we_n)) |=>
      (mem_wr && mem_wdata == $past(data_in)));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  a_r6_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ce_n) |=> !mem_wr);

  a_r8_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> (!data_oe && data_out == '0));

  a_r9_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !status_ready) |-> !rdy_busy);

  a_r2_inert_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (rdy_busy && !data_oe && !mem_wr));

  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

bind rcm_prog_port rcm_port_checker #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .addr_pins(addr_pins),
  .rc_sel(rc_sel), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .data_in(data_in),
  .data_out(data_out), .data_oe(data_oe), .rdy_busy(rdy_busy),
  .asm_addr(asm_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
  .status_ready(status_ready)
);

// File: tb/rcm_prog_port_tb.sv
module rcm_prog_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_strap = 1'b1;
  logic [10:0] addr_pins = '0;
  logic        rc_sel = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0]  data_in = '0;
  logic [7:0]  data_out;
  logic        data_oe, rdy_busy, mem_wr, mem_rd;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        status_ready = 1'b1;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  // Array model: read data derived from the address.
  function automatic logic [7:0] model_rd(input logic [19:0] a);
    return a[7:0] ^ a[19:12] ^ 8'h5A;
  endfunction
  assign mem_rdata = model_rd(mem_addr);

  rcm_prog_port dut_i (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .addr_pins(addr_pins),
    .rc_sel(rc_sel), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .rdy_busy(rdy_busy),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata), .status_ready(status_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit strap);
    rst_n = 1'b0; mode_strap = strap;
    rc_sel = 1'b1; we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic set_addr(input logic [10:0] row, input logic [10:0] colpins);
    addr_pins = row; rc_sel = 1'b0; tick();
    addr_pins = colpins; rc_sel = 1'b1; tick();
    addr_pins = 11'h7FF;
  endtask

  task automatic pulse_we(input logic [7:0] d);
    data_in = d; we_n = 1'b0; tick();
    we_n = 1'b1; tick();
    data_in = 8'h00;
  endtask

  // row(11), column pins(11, upper two bits must be ignored), write data(8)
  localparam int NV = 6;
  localparam logic [29:0] VEC [NV] = '{
    {11'h000, 11'h600, 8'hA5},
    {11'h7FF, 11'h1FF, 8'h3C},
    {11'h555, 11'h2AA, 8'hFF},
    {11'h2AA, 11'h555, 8'h00},
    {11'h001, 11'h401, 8'h81},
    {11'h400, 11'h100, 8'h7E}
  };

  initial begin
    do_reset(1'b1);
    // R1: reset state
    chk(mem_addr == 20'h0, "R1 addr", mem_addr, 0);
    chk(!mem_wr && !data_oe && data_out == 8'h0, "R1 idle", {mem_wr, data_oe}, 0);
    chk(rdy_busy == 1'b1, "R9 ready", rdy_busy, 1);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] row, cp;
      logic [7:0]  d;
      logic [19:0] ea;
      {row, cp, d} = VEC[i];
      ea = {cp[8:0], row};
      ce_n = 1'b0;
      set_addr(row, cp);
      chk(mem_addr == ea, "R3 R4 assembled", mem_addr, ea);
      pulse_we(d);
      chk(mem_wr == 1'b1, "R5 pulse", mem_wr, 1);
      chk(mem_wdata == d, "R5 data", mem_wdata, d);
      chk(mem_addr == ea, "R5 addr", mem_addr, ea);
      tick();
      chk(mem_wr == 1'b0, "R5 one cycle", mem_wr, 0);
      oe_n = 1'b0; tick();
      chk(data_oe && mem_rd, "R7 enable", {data_oe, mem_rd}, 3);
      chk(data_out == model_rd(ea), "R7 data", data_out, model_rd(ea));
      oe_n = 1'b1; ce_n = 1'b1; tick();
      chk(!data_oe && data_out == 8'h0, "R8 released", data_out, 0);
    end

    // R3: row-only change keeps the column
    ce_n = 1'b0;
    set_addr(11'h123, 11'h0AB);
    addr_pins = 11'h456; rc_sel = 1'b0; tick();
    chk(mem_addr == {9'h0AB, 11'h456}, "R3 row only", mem_addr, {9'h0AB, 11'h456});
    rc_sel = 1'b1; addr_pins = 11'h700; tick();
    // R4: upper pins ignored in column phase
    chk(mem_addr[19:11] == 9'h100, "R4 upper ignored", mem_addr[19:11], 9'h100);

    // R6: write while deselected
    ce_n = 1'b1; data_in = 8'h11; we_n = 1'b0; tick(); we_n = 1'b1; tick();
    chk(mem_wr == 1'b0, "R6 deselected write", mem_wr, 0);
    tick();
    chk(mem_wr == 1'b0, "R6 later", mem_wr, 0);

    // R8: outputs off with ce high, oe low
    oe_n = 1'b0; tick();
    chk(!data_oe && data_out == 8'h0, "R8 ce high", data_oe, 0);
    // R7: we_n low blocks read
    ce_n = 1'b0; we_n = 1'b0; tick();
    chk(!data_oe && !mem_rd, "R7 we low", data_oe, 0);
    we_n = 1'b1; tick(); oe_n = 1'b1; tick();

    // R9: busy
    status_ready = 1'b0; tick();
    chk(rdy_busy == 1'b0, "R9 busy", rdy_busy, 0);
    status_ready = 1'b1; tick();
    chk(rdy_busy == 1'b1, "R9 ready again", rdy_busy, 1);

    // R10: strap toggle after reset has no effect
    mode_strap = 1'b0; tick(2);
    ce_n = 1'b0; pulse_we(8'h42);
    chk(mem_wr == 1'b1 && mem_wdata == 8'h42, "R10 still active", mem_wdata, 8'h42);
    ce_n = 1'b1; tick();

    // R2: inert mode
    do_reset(1'b0);
    status_ready = 1'b0;
    ce_n = 1'b0; pulse_we(8'h99);
    chk(mem_wr == 1'b0, "R2 no write", mem_wr, 0);
    oe_n = 1'b0; tick();
    chk(!data_oe && !mem_rd && data_out == 8'h0, "R2 no read", data_oe, 0);
    chk(rdy_busy == 1'b1, "R2 ready high", rdy_busy, 1);
    oe_n = 1'b1; ce_n = 1'b1;
    mode_strap = 1'b1; tick(2);
    chk(rdy_busy == 1'b1, "R10 stays inert", rdy_busy, 1);
    status_ready = 1'b1;

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule